// File: doc/BRIEF.md
# Suspend Entry Sequencer

This block decides when a processor bus interface may enter its low-power suspend state. A suspend can be requested in two ways: an external active-low request pin, or an internal halt indication raised when a halt instruction executes. Either one starts the same entry sequence.

Entry is not immediate. The sequencer first waits for the instruction in flight to retire. It then waits until the queue of already decoded instructions is empty and the bus has gone idle. Finally it waits until the attached coprocessor reports that it is not busy. Only after these three conditions have been met, one after another, does it drive the active-low suspend acknowledge. The acknowledge is released once the request goes away.

The external pin is asynchronous, so it passes through a synchronizer whose depth is a parameter. The halt indication comes from on-chip logic and is used as it is. Clock gating, instruction decode and the coprocessor itself belong to other blocks.

Top module: `susp_seq_ctrl`

## Requirements
- R1: While `susp_req_n` is 1 (no request, which is also the level of an undriven pin) and `halt_req` is 0, `susp_ack_n` stays 1 whatever the completion inputs do.
- R2: Once a request is recognised, the sequence does not pass the instruction-retire step until `instr_done` is 1.
- R3: After the instruction step, the sequence waits until `queue_empty` and `bus_idle` are both 1. Either one alone does not let it advance.
- R4: After the drain step, the sequence waits until `copro_busy_n` is 1 (coprocessor not busy).
- R5: `susp_ack_n` goes to 0 only after all wait steps have completed. With every completion input held at 1, it falls exactly SYNC_STAGES+4 rising edges after `susp_req_n` is driven to 0.
- R6: `halt_req` = 1 produces the same acknowledge without passing through the synchronizer. With all completion inputs at 1, `susp_ack_n` falls 4 edges after `halt_req` rises.
- R7: When the request is withdrawn during suspend, `susp_ack_n` returns to 1. This happens SYNC_STAGES+1 edges after `susp_req_n` returns to 1, or 1 edge after `halt_req` falls.
- R8: An active-high synchronous `rst` returns the block to idle, with `susp_ack_n` at 1 after the next edge, even from the suspended state.
- R9: The steps are taken strictly in order, one per clock at most. Readiness of a later step never lets an earlier step be skipped. After `instr_done` rises in the first step, the acknowledge falls exactly 3 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| susp_req_n | input | 1 | External suspend request, active low, asynchronous |
| halt_req | input | 1 | Halt instruction executed; held at 1 until an interrupt ends the halt |
| instr_done | input | 1 | Current instruction has retired |
| queue_empty | input | 1 | Decoded-instruction queue is empty |
| bus_idle | input | 1 | No bus cycle is outstanding |
| copro_busy_n | input | 1 | Coprocessor busy, active low (1 = not busy) |
| susp_ack_n | output | 1 | Suspend acknowledge, active low |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default 2. This shows that the pin-path entry and release latencies grow with the synchronizer depth, while the halt path stays at a fixed latency. Each completion input is held low on its own for many cycles to show that its step blocks the sequence. The bench then measures the exact number of edges from release to acknowledge. This makes any skipped, merged or reordered step visible as a wrong latency.

// File: rtl/susp_pkg.sv
package susp_pkg;

  typedef enum logic [2:0] {
    S_IDLE        = 3'd0,
    S_DRAIN_INSTR = 3'd1,
    S_DRAIN_BUS   = 3'd2,
    S_WAIT_COPRO  = 3'd3,
    S_SUSPENDED   = 3'd4
  } susp_state_e;

  // One step of the entry sequence: each state looks only at its own gate.
  function automatic susp_state_e next_step(
    input susp_state_e cur,
    input logic        req,
    input logic        instr_ok,
    input logic        drain_ok,
    input logic        copro_ok
  );
    susp_state_e nxt;
    nxt = cur;
    case (cur)
      S_IDLE:        if (req)      nxt = S_DRAIN_INSTR;
      S_DRAIN_INSTR: if (instr_ok) nxt = S_DRAIN_BUS;
      S_DRAIN_BUS:   if (drain_ok) nxt = S_WAIT_COPRO;
      S_WAIT_COPRO:  if (copro_ok) nxt = S_SUSPENDED;
      S_SUSPENDED:   if (!req)     nxt = S_IDLE;
      default:                     nxt = S_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/susp_req_sync.sv
module susp_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic sync_n
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_n = async_n;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;   // reset to "no request"
        else     chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], async_n};
      end
      assign sync_n = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/susp_step_fsm.sv
module susp_step_fsm
  import susp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        instr_ok,
  input  logic        drain_ok,
  input  logic        copro_ok,
  output susp_state_e state
);
  susp_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= next_step(state_q, req, instr_ok, drain_ok, copro_ok);
  end

  assign state = state_q;
endmodule

// File: rtl/susp_seq_ctrl.sv
module susp_seq_ctrl
  import susp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic susp_req_n,
  input  logic halt_req,
  input  logic instr_done,
  input  logic queue_empty,
  input  logic bus_idle,
  input  logic copro_busy_n,
  output logic susp_ack_n
);
  logic        pin_req_n_s;
  logic        req_active;
  logic        drain_ok;
  susp_state_e state;

  susp_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (susp_req_n),
    .sync_n  (pin_req_n_s)
  );

  // Named events for the checker
  assign req_active = !pin_req_n_s || halt_req;
  assign drain_ok   = queue_empty && bus_idle;

  susp_step_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req_active),
    .instr_ok (instr_done),
    .drain_ok (drain_ok),
    .copro_ok (copro_busy_n),
    .state    (state)
  );

  assign susp_ack_n = (state != S_SUSPENDED);
endmodule

// File: rtl/susp_seq_ctrl_chk.sv
module susp_seq_ctrl_chk
  import susp_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        susp_ack_n,
  input logic        instr_done,
  input logic        queue_empty,
  input logic        bus_idle,
  input logic        copro_busy_n,
  input logic        req_active,
  input susp_state_e state
);
  // R1: no request keeps the block idle
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !req_active) |=> (state == S_IDLE));

  // R2: leaving the instruction step needs instr_done
  a_r2_instr_gate: assert property (@(posedge clk) disable iff (rst)
    ($past(state == S_DRAIN_INSTR) && state == S_DRAIN_BUS) |-> $past(instr_done));

  // R3: leaving the drain step needs both queue and bus idle
  a_r3_drain_gate: assert property (@(posedge clk) disable iff (rst)
    ($past(state == S_DRAIN_BUS) && state == S_WAIT_COPRO) |-> $past(queue_empty && bus_idle));

  // R4: acknowledge falls only when the coprocessor was not busy
  a_r4_copro_gate: assert property (@(posedge clk) disable iff (rst)
    $fell(susp_ack_n) |-> $past(copro_busy_n));

  // R7: withdrawn request releases the acknowledge on the next edge
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (state == S_SUSPENDED && !req_active) |=> susp_ack_n);

  // R8: reset releases the acknowledge
  a_r8_reset: assert property (@(posedge clk)
    rst |=> susp_ack_n);

  // R9: idle may only exit into the first wait step
  a_r9_order: assert property (@(posedge clk) disable iff (rst)
    ($past(state == S_IDLE) && state != S_IDLE) |-> (state == S_DRAIN_INSTR));
endmodule

bind susp_seq_ctrl susp_seq_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .susp_ack_n   (susp_ack_n),
  .instr_done   (instr_done),
  .queue_empty  (queue_empty),
  .bus_idle     (bus_idle),
  .copro_busy_n (copro_busy_n),
  .req_active   (req_active),
  .state        (state)
);

// File: tb/susp_seq_ctrl_tb_top.sv
module susp_seq_ctrl_tb_top;
  localparam int SYNC = 3;
  localparam time HALF = 4ns;

  logic clk = 1'b0;
  logic rst, susp_req_n, halt_req, instr_done, queue_empty, bus_idle, copro_busy_n;
  logic susp_ack_n;
  int checks = 0;
  int errors = 0;

  always #HALF clk = ~clk;

  susp_seq_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .susp_req_n(susp_req_n), .halt_req(halt_req),
    .instr_done(instr_done), .queue_empty(queue_empty), .bus_idle(bus_idle),
    .copro_busy_n(copro_busy_n), .susp_ack_n(susp_ack_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2ns;
  endtask

  task automatic chk(input string req, input logic exp, input string what);
    checks++;
    if (susp_ack_n !== exp) begin
      errors++;
      $display("FAIL %s %s: susp_ack_n actual %b expected %b", req, what, susp_ack_n, exp);
    end
  endtask

  task automatic all_ready();
    susp_req_n = 1'b1; halt_req = 1'b0; instr_done = 1'b1;
    queue_empty = 1'b1; bus_idle = 1'b1; copro_busy_n = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1; all_ready();
    tick(3);
    chk("R8", 1'b1, "after reset");
    rst = 1'b0;
    tick(10);
    chk("R1", 1'b1, "ready inputs but no request");
  endtask

  task automatic t_pin_entry_release();
    susp_req_n = 1'b0;
    tick(SYNC + 3);
    chk("R5", 1'b1, "one edge before entry");
    tick(1);
    chk("R5", 1'b0, "entry latency SYNC+4");
    susp_req_n = 1'b1;
    tick(SYNC);
    chk("R7", 1'b0, "held before sync release");
    tick(1);
    chk("R7", 1'b1, "pin release SYNC+1");
    tick(3);
  endtask

  task automatic t_instr_gate();
    instr_done = 1'b0;
    susp_req_n = 1'b0;
    tick(SYNC + 12);
    chk("R2", 1'b1, "instr not retired");
    instr_done = 1'b1;
    tick(2);
    chk("R9", 1'b1, "no skip after instr_done");
    tick(1);
    chk("R9", 1'b0, "3 edges after instr_done");
    susp_req_n = 1'b1;
    tick(SYNC + 4);
  endtask

  task automatic t_drain_gate();
    queue_empty = 1'b0;
    susp_req_n = 1'b0;
    tick(SYNC + 12);
    chk("R3", 1'b1, "queue not empty");
    queue_empty = 1'b1; bus_idle = 1'b0;
    tick(6);
    chk("R3", 1'b1, "bus still busy");
    bus_idle = 1'b1;
    tick(1);
    chk("R3", 1'b1, "one edge after drain");
    tick(1);
    chk("R3", 1'b0, "two edges after drain");
    susp_req_n = 1'b1;
    tick(SYNC + 4);
  endtask

  task automatic t_copro_gate();
    copro_busy_n = 1'b0;
    susp_req_n = 1'b0;
    tick(SYNC + 12);
    chk("R4", 1'b1, "coprocessor busy");
    copro_busy_n = 1'b1;
    tick(1);
    chk("R4", 1'b0, "one edge after not busy");
    susp_req_n = 1'b1;
    tick(SYNC + 4);
  endtask

  task automatic t_halt();
    halt_req = 1'b1;
    tick(3);
    chk("R6", 1'b1, "halt one edge early");
    tick(1);
    chk("R6", 1'b0, "halt latency 4");
    halt_req = 1'b0;
    tick(1);
    chk("R7", 1'b1, "halt release 1 edge");
    tick(3);
  endtask

  task automatic t_reset_in_suspend();
    halt_req = 1'b1;
    tick(4);
    chk("R6", 1'b0, "suspended before reset");
    rst = 1'b1;
    tick(1);
    chk("R8", 1'b1, "reset from suspend");
    halt_req = 1'b0;
    tick(1);
    rst = 1'b0;
    tick(5);
    chk("R1", 1'b1, "idle after reset");
  endtask

  initial begin
    #(HALF * 2 * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; all_ready();
    #1ns;
    t_reset();
    t_pin_entry_release();
    t_instr_gate();
    t_drain_gate();
    t_copro_gate();
    t_halt();
    t_reset_in_suspend();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule